// File: doc/BRIEF.md
# EEPROM Bank Write-Protection Sequence Guard

This block sits between the byte-write capture logic and the page programming sequencer of an electrically erasable memory. It receives every captured byte write (bank index, 17-bit address, 8-bit data) and, in the same cycle, classifies it in one of three ways. A command byte is part of a protection code sequence and is never stored. A permitted write may be programmed. A swallowed write starts the normal write timing but must leave the array untouched.

Each bank holds its own protection flag, its own sequence matcher and its own write session. Protection is turned on, and each later write to a protected bank is authorised, by one three-byte code. A six-byte code turns protection off. A flag change takes effect only when the page sequencer signals the end of that bank's write period. Flags return to their initial value only through the reset input.

Top module: `eeprom_wp_guard`

## Requirements
- R1: Asserting `rst_n` low (asynchronous) sets every protect flag to its parameter initial value (default 0, unprotected), returns every matcher to idle and ends every session. No other input clears a flag.
- R2: A data write to a bank whose flag is 0 gives `wr_permit`=1, `wr_swallow`=0, `wr_cmd`=0.
- R3: With `wr_valid`=1, exactly one of `wr_permit`, `wr_swallow` and `wr_cmd` is 1; with `wr_valid`=0 all three are 0. The bytes of a code sequence give `wr_cmd`=1, and idle cycles between them do not break the sequence.
- R4: The lock code is data 0xAA at address 0x05555, then 0x55 at 0x02AAA, then 0xA0 at 0x05555. After it, that bank's flag becomes 1 on the clock edge where its `period_end` bit is 1, even when no data byte followed. The flag is visible on `prot_flags` from the next cycle.
- R5: On a bank whose flag is 1, a data write made outside a session gives `wr_swallow`=1 and `wr_permit`=0.
- R6: A completed lock or unlock code opens a session on that bank. Every later data write to that bank, at any address, is permitted until that bank's `period_end`. The flag stays 1 after a session on a protected bank.
- R7: Writes and `period_end` bits aimed at one bank leave the flag, matcher and session of every other bank unchanged.
- R8: A byte that does not match the next expected code byte returns the matcher to idle and is classified as a data write under the current flag and session.
- R9: The unlock code is 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555. The flag stays 1 until that bank's next `period_end` and is 0 afterwards, even with no data byte loaded.
- R10: A `period_end` pulse ends the bank's session and discards any partly matched code, so the remaining bytes of that code are then treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A captured byte write is present this cycle |
| wr_bank | input | BANK_W (1) | Bank index of the write |
| wr_addr | input | ADDR_W (17) | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| period_end | input | NUM_BANKS (2) | Per-bank pulse marking the end of that bank's write period |
| prot_flags | output | NUM_BANKS (2) | Current protect flag of each bank |
| wr_permit | output | 1 | Current write may be programmed |
| wr_swallow | output | 1 | Current write runs the timer but stores nothing |
| wr_cmd | output | 1 | Current write is a code byte and is not stored |

## Verification
On every cycle, the assertions check that the three classification outputs are mutually exclusive and zero when idle, that a swallowed write only ever hits a protected bank, that a flag moves only on its bank's period end, and that a completed lock code or a period end leaves the matcher in the required state. Whether the right codes at the right addresses are recognised, whether broken sequences fall back to data, whether banks stay independent and whether the flag holds across authorised sessions can only be shown by the bench's scenarios. The bench compares every cycle against its behavioural model.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

   localparam int unsigned BYTE_W = 8;

   // code byte values of the protection sequences
   localparam logic [BYTE_W-1:0] CODE_LEAD   = 8'hAA;
   localparam logic [BYTE_W-1:0] CODE_SECOND = 8'h55;
   localparam logic [BYTE_W-1:0] CODE_LOCK   = 8'hA0;
   localparam logic [BYTE_W-1:0] CODE_ESCAPE = 8'h80;
   localparam logic [BYTE_W-1:0] CODE_CLEAR  = 8'h20;

   // what one captured byte looks like to a matcher
   typedef enum logic [2:0] {
      TK_NONE,
      TK_LEAD,
      TK_SECOND,
      TK_LOCK,
      TK_ESCAPE,
      TK_CLEAR
   } tok_t;

   // progress through a code sequence
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GOT1,
      ST_GOT2,
      ST_ESC3,
      ST_ESC4,
      ST_ESC5
   } step_t;

   typedef struct packed {
      logic permit;
      logic swallow;
      logic cmd;
   } wr_class_t;

endpackage

// File: rtl/ewp_token_dec.sv
module ewp_token_dec
   import ewp_pkg::*;
#(
   parameter int unsigned       ADDR_W = 17,
   parameter logic [ADDR_W-1:0] KEY_P  = ADDR_W'('h5555),
   parameter logic [ADDR_W-1:0] KEY_Q  = ADDR_W'('h2AAA)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] data,
   output tok_t              tok
);

   logic at_p, at_q;

   assign at_p = (addr == KEY_P);
   assign at_q = (addr == KEY_Q);

   always_comb begin
      tok = TK_NONE;
      if (at_p) begin
         if      (data == CODE_LEAD)   tok = TK_LEAD;
         else if (data == CODE_LOCK)   tok = TK_LOCK;
         else if (data == CODE_ESCAPE) tok = TK_ESCAPE;
         else if (data == CODE_CLEAR)  tok = TK_CLEAR;
      end else if (at_q && data == CODE_SECOND) begin
         tok = TK_SECOND;
      end
   end

endmodule

// File: rtl/ewp_bank_ctl.sv
module ewp_bank_ctl
   import ewp_pkg::*;
#(
   parameter logic PROT_INIT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel,
   input  logic      period_end,
   input  tok_t      tok,
   output wr_class_t cls,
   output logic      prot
);

   step_t st_q, st_d, adv;
   logic  unlock_q, unlock_d;
   logic  pend_set_q, pend_set_d;
   logic  pend_clr_q, pend_clr_d;
   logic  prot_q, prot_d;
   logic  is_cmd, arm_set, arm_clr;

   // matcher step: where this byte takes the sequence
   always_comb begin
      is_cmd  = 1'b0;
      arm_set = 1'b0;
      arm_clr = 1'b0;
      adv     = ST_IDLE;
      case (st_q)
         ST_IDLE: if (tok == TK_LEAD) begin
            is_cmd = 1'b1;
            adv    = ST_GOT1;
         end
         ST_GOT1: if (tok == TK_SECOND) begin
            is_cmd = 1'b1;
            adv    = ST_GOT2;
         end
         ST_GOT2: if (tok == TK_LOCK) begin
            is_cmd  = 1'b1;
            arm_set = 1'b1;
         end else if (tok == TK_ESCAPE) begin
            is_cmd = 1'b1;
            adv    = ST_ESC3;
         end
         ST_ESC3: if (tok == TK_LEAD) begin
            is_cmd = 1'b1;
            adv    = ST_ESC4;
         end
         ST_ESC4: if (tok == TK_SECOND) begin
            is_cmd = 1'b1;
            adv    = ST_ESC5;
         end
         ST_ESC5: if (tok == TK_CLEAR) begin
            is_cmd  = 1'b1;
            arm_clr = 1'b1;
         end
         default: ;
      endcase
   end

   // classification of the current byte
   assign cls.cmd     = sel & is_cmd;
   assign cls.permit  = sel & ~is_cmd & (unlock_q | ~prot_q);
   assign cls.swallow = sel & ~is_cmd & ~unlock_q & prot_q;
   assign prot        = prot_q;

   // state update; a period end outranks a write in the same cycle
   always_comb begin
      st_d       = st_q;
      unlock_d   = unlock_q;
      pend_set_d = pend_set_q;
      pend_clr_d = pend_clr_q;
      prot_d     = prot_q;
      if (period_end) begin
         if (pend_clr_q)      prot_d = 1'b0;
         else if (pend_set_q) prot_d = 1'b1;
         st_d       = ST_IDLE;
         unlock_d   = 1'b0;
         pend_set_d = 1'b0;
         pend_clr_d = 1'b0;
      end else if (sel) begin
         st_d = adv;
         if (arm_set) begin
            unlock_d   = 1'b1;
            pend_set_d = 1'b1;
            pend_clr_d = 1'b0;
         end
         if (arm_clr) begin
            unlock_d   = 1'b1;
            pend_clr_d = 1'b1;
            pend_set_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         unlock_q   <= 1'b0;
         pend_set_q <= 1'b0;
         pend_clr_q <= 1'b0;
         prot_q     <= PROT_INIT;
      end else begin
         st_q       <= st_d;
         unlock_q   <= unlock_d;
         pend_set_q <= pend_set_d;
         pend_clr_q <= pend_clr_d;
         prot_q     <= prot_d;
      end
   end

   // flag moves only at the end of a write period
   assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(prot_q))
      else $error("protect flag changed without period end");

   // a finished lock code opens a session and arms the flag
   assert_lock_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !period_end && st_q == ST_GOT2 && tok == TK_LOCK)
      |=> (unlock_q && pend_set_q && st_q == ST_IDLE))
      else $error("lock code did not open a session");

   // period end closes the session and drops partial codes
   assert_session_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> (!unlock_q && !pend_set_q && !pend_clr_q && st_q == ST_IDLE))
      else $error("session survived period end");

endmodule

// File: rtl/eeprom_wp_guard.sv
module eeprom_wp_guard
   import ewp_pkg::*;
#(
   parameter int unsigned          NUM_BANKS  = 2,
   parameter int unsigned          ADDR_W     = 17,
   parameter logic [ADDR_W-1:0]    KEY_ADDR_P = ADDR_W'('h5555),
   parameter logic [ADDR_W-1:0]    KEY_ADDR_Q = ADDR_W'('h2AAA),
   parameter logic [NUM_BANKS-1:0] PROT_INIT  = '0,
   parameter bit                   SHARED_DEC = 1'b1,
   localparam int unsigned         BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [BANK_W-1:0]    wr_bank,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [BYTE_W-1:0]    wr_data,
   input  logic [NUM_BANKS-1:0] period_end,
   output logic [NUM_BANKS-1:0] prot_flags,
   output logic                 wr_permit,
   output logic                 wr_swallow,
   output logic                 wr_cmd
);

   // elaboration-time parameter checks
   if (NUM_BANKS < 1 || NUM_BANKS > 64) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..64");
   end
   if (ADDR_W < 15) begin : g_bad_addr
      $error("ADDR_W too narrow for the code addresses");
   end
   if (KEY_ADDR_P == KEY_ADDR_Q) begin : g_bad_keys
      $error("the two code addresses must differ");
   end

   logic      sel_b [NUM_BANKS];
   tok_t      tok_b [NUM_BANKS];
   wr_class_t cls_b [NUM_BANKS];
   wr_class_t cls_any;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
      assign sel_b[i] = wr_valid && (wr_bank == BANK_W'(i));
   end

   if (SHARED_DEC) begin : g_dec_shared
      // one decoder fanned out to every bank
      tok_t tok_one;
      ewp_token_dec #(
         .ADDR_W (ADDR_W),
         .KEY_P  (KEY_ADDR_P),
         .KEY_Q  (KEY_ADDR_Q)
      ) u_dec (
         .addr (wr_addr),
         .data (wr_data),
         .tok  (tok_one)
      );
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_fan
         assign tok_b[i] = tok_one;
      end
   end else begin : g_dec_local
      // one isolated decoder per bank; unselected banks see zeros
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_one
         ewp_token_dec #(
            .ADDR_W (ADDR_W),
            .KEY_P  (KEY_ADDR_P),
            .KEY_Q  (KEY_ADDR_Q)
         ) u_dec (
            .addr (sel_b[i] ? wr_addr : '0),
            .data (sel_b[i] ? wr_data : '0),
            .tok  (tok_b[i])
         );
      end
   end

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      ewp_bank_ctl #(
         .PROT_INIT (PROT_INIT[i])
      ) u_ctl (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel        (sel_b[i]),
         .period_end (period_end[i]),
         .tok        (tok_b[i]),
         .cls        (cls_b[i]),
         .prot       (prot_flags[i])
      );
   end

   always_comb begin
      cls_any = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         cls_any = wr_class_t'(cls_any | cls_b[i]);
      end
   end

   assign wr_permit  = cls_any.permit;
   assign wr_swallow = cls_any.swallow;
   assign wr_cmd     = cls_any.cmd;

   // exactly one class per write to an existing bank, none when idle
   assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && 32'(wr_bank) < NUM_BANKS) |-> $countones({wr_permit, wr_swallow, wr_cmd}) == 1)
      else $error("write classified ambiguously");

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> !(wr_permit || wr_swallow || wr_cmd))
      else $error("class output without a write");

   // a swallowed write must target a protected bank
   assert_swallow_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_swallow |-> ((prot_flags >> wr_bank) & NUM_BANKS'(1)) != '0)
      else $error("swallow on an unprotected bank");

endmodule

// File: tb/eeprom_wp_guard_tb_top.sv
module eeprom_wp_guard_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam logic [16:0] KP = 17'h05555;
   localparam logic [16:0] KQ = 17'h02AAA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_bank = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  period_end = '0;
   logic [1:0]  prot_flags;
   logic        wr_permit, wr_swallow, wr_cmd;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // behavioural model state, per bank
   int          m_step [2];
   bit          m_unl  [2];
   bit          m_pset [2];
   bit          m_pclr [2];
   bit          m_prot [2];
   logic [16:0] seq_a  [6];
   logic [7:0]  seq_d  [6];

   eeprom_wp_guard dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .wr_bank    (wr_bank),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .period_end (period_end),
      .prot_flags (prot_flags),
      .wr_permit  (wr_permit),
      .wr_swallow (wr_swallow),
      .wr_cmd     (wr_cmd)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
         finish_up();
      end
   end

   function automatic void model_clear();
      for (int i = 0; i < 2; i++) begin
         m_step[i] = 0; m_unl[i] = 0; m_pset[i] = 0; m_pclr[i] = 0; m_prot[i] = 0;
      end
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive, compare against model, advance model
   task automatic step_cyc(input bit v, input int b, input logic [16:0] a, input logic [7:0] d,
                           input logic [1:0] pe, input string tag);
      bit ep, es, ec;
      int p;
      @(negedge clk);
      wr_valid = v; wr_bank = b[0]; wr_addr = a; wr_data = d; period_end = pe;
      #1;
      ep = 0; es = 0; ec = 0;
      if (v) begin
         p = m_step[b];
         if (p == 2 && a == KP && d == 8'hA0) begin
            ec = 1; m_step[b] = 0; m_unl[b] = 1; m_pset[b] = 1; m_pclr[b] = 0;
         end else if (a == seq_a[p] && d == seq_d[p]) begin
            ec = 1;
            if (p == 5) begin
               m_step[b] = 0; m_unl[b] = 1; m_pclr[b] = 1; m_pset[b] = 0;
            end else begin
               m_step[b] = p + 1;
            end
         end else begin
            m_step[b] = 0;
            ep = m_unl[b] || !m_prot[b];
            es = !ep;
         end
      end
      chk({wr_permit, wr_swallow, wr_cmd} === {ep, es, ec}, tag, "class {permit,swallow,cmd}",
          int'({wr_permit, wr_swallow, wr_cmd}), int'({ep, es, ec}));
      chk(prot_flags === {m_prot[1], m_prot[0]}, tag, "protect flags",
          int'(prot_flags), int'({m_prot[1], m_prot[0]}));
      for (int i = 0; i < 2; i++) begin
         if (pe[i]) begin
            if (m_pclr[i])      m_prot[i] = 0;
            else if (m_pset[i]) m_prot[i] = 1;
            m_step[i] = 0; m_unl[i] = 0; m_pset[i] = 0; m_pclr[i] = 0;
         end
      end
   endtask

   task automatic wr(input int b, input logic [16:0] a, input logic [7:0] d, input string tag);
      step_cyc(1'b1, b, a, d, 2'b00, tag);
   endtask

   task automatic pend(input logic [1:0] mask, input string tag);
      step_cyc(1'b0, 0, '0, '0, mask, tag);
   endtask

   task automatic idle(input string tag);
      step_cyc(1'b0, 0, '0, '0, 2'b00, tag);
   endtask

   task automatic lock_code(input int b, input string tag);
      wr(b, KP, 8'hAA, tag);
      wr(b, KQ, 8'h55, tag);
      wr(b, KP, 8'hA0, tag);
   endtask

   task automatic unlock_code(input int b, input string tag);
      wr(b, KP, 8'hAA, tag);
      wr(b, KQ, 8'h55, tag);
      wr(b, KP, 8'h80, tag);
      wr(b, KP, 8'hAA, tag);
      wr(b, KQ, 8'h55, tag);
      wr(b, KP, 8'h20, tag);
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0; wr_valid = 1'b0; period_end = '0;
      model_clear();
      #1;
      chk(prot_flags === 2'b00, tag, "protect flags in reset", int'(prot_flags), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      seq_a[0] = KP; seq_a[1] = KQ; seq_a[2] = KP; seq_a[3] = KP; seq_a[4] = KQ; seq_a[5] = KP;
      seq_d[0] = 8'hAA; seq_d[1] = 8'h55; seq_d[2] = 8'h80;
      seq_d[3] = 8'hAA; seq_d[4] = 8'h55; seq_d[5] = 8'h20;
      model_clear();

      // R1: reset state, outputs quiet
      idle("R1");
      idle("R1");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");

      // R2: unprotected banks permit plain data
      wr(0, 17'h01234, 8'h5A, "R2");
      wr(1, 17'h1FFFF, 8'hC3, "R2");
      wr(0, KQ, 8'h55, "R2");

      // R3/R4: lock code on bank 0 with one data byte, then period end
      lock_code(0, "R3");
      wr(0, 17'h00100, 8'h11, "R6");
      idle("R4");
      pend(2'b01, "R4");
      idle("R4");

      // R5: protected bank swallows; R7: other bank unaffected
      wr(0, 17'h00200, 8'h22, "R5");
      wr(1, 17'h00200, 8'h22, "R7");

      // R4: lock with no data byte on bank 1
      lock_code(1, "R4");
      pend(2'b10, "R4");
      idle("R4");

      // R6: authorised burst on protected bank 0
      lock_code(0, "R6");
      for (int k = 0; k < 5; k++) wr(0, 17'h00300 + 17'(k), 8'(8'h40 + k), "R6");
      wr(1, 17'h00400, 8'h99, "R7");
      pend(2'b01, "R6");
      wr(0, 17'h00300, 8'h77, "R6");

      // R8: early and late mismatches become data
      wr(0, KP, 8'hAA, "R8");
      wr(0, KQ, 8'h12, "R8");
      wr(0, KQ, 8'h55, "R8");
      wr(0, KP, 8'hAA, "R8");
      wr(0, KQ, 8'h55, "R8");
      wr(0, KP, 8'h80, "R8");
      wr(0, KP, 8'hAA, "R8");
      wr(0, KQ, 8'h77, "R8");
      wr(0, KP, 8'hA0, "R8");

      // R3: idle gaps inside a code do not break it
      wr(1, KP, 8'hAA, "R3");
      idle("R3");
      wr(1, KQ, 8'h55, "R3");
      idle("R3");
      wr(1, KP, 8'hA0, "R3");
      wr(1, 17'h00010, 8'h01, "R3");
      pend(2'b10, "R3");

      // R9: unlock code on bank 0, flag held until period end
      unlock_code(0, "R9");
      wr(0, 17'h00500, 8'h55, "R9");
      idle("R9");
      pend(2'b01, "R9");
      wr(0, 17'h00501, 8'h56, "R9");
      wr(1, 17'h00501, 8'h56, "R7");

      // R10: period end discards a partial code
      wr(1, KP, 8'hAA, "R10");
      wr(1, KQ, 8'h55, "R10");
      pend(2'b10, "R10");
      wr(1, KP, 8'hA0, "R10");
      wr(1, 17'h00600, 8'h60, "R10");

      // R9: unlock with no data byte on bank 1
      unlock_code(1, "R9");
      pend(2'b10, "R9");
      wr(1, 17'h00700, 8'h70, "R9");

      // R1: only reset clears a set flag
      lock_code(0, "R1");
      pend(2'b01, "R1");
      idle("R1");
      do_reset("R1");
      idle("R1");
      wr(0, 17'h00800, 8'h80, "R1");

      finish_up();
   end

endmodule